// File: doc/BRIEF.md
# Mixed-Aspect-Ratio Two-Port RAM

This block is a synthesizable behavioural model of a 4608-bit on-chip RAM with one write port and one read port. Each port runs on its own clock and carries its own 3-bit organization code, chosen at run time. A word written at one width can therefore be read back at another width, which gives a bus-width converter built into the storage itself. Both address buses are 12 bits wide and both data buses are 36 bits wide. In the narrower organizations only the low data bits are used.

Storage is 512 groups of 9 bits. The 36-, 18- and 9-bit organizations use every bit of each group. The 4-, 2- and 1-bit organizations use only the low 8 bits of each group, which gives 4096 bits. Inside any 36-bit row, a narrower word with a lower address sits at lower bit positions, so data read back at another width comes out in a predictable order. Reads are registered. The read output register is the only state that reset touches.

Top module: `mixed_ratio_ram`

## Requirements
- R1: Each port decodes its 3-bit organization code as follows: 101 = 128x36, 100 = 256x18, 011 = 512x9, 010 = 1024x4, 001 = 2048x2, 000 = 4096x1.
- R2: On a rising edge of wrClk with wrEn high, the addressed word is stored. Reading the same address back with the same organization returns that word.
- R3: In an organization of width W, only wrData[W-1:0] is stored, and rdData bits W and above read as zero.
- R4: For 36-, 18- and 9-bit words, 9-bit group g holds bits 9*(g mod 4) and up of 36-bit row g/4. Word a of width 18 covers groups 2a and 2a+1, with the low half in 2a. Word a of width 9 is group a.
- R5: For 4-, 2- and 1-bit words, word a of width W occupies bits W*(a mod (8/W)) and up of group a*W/8. Bit 8 of every group is left unchanged by these writes.
- R6: rdData takes the addressed word on the first rdClk rising edge at which rdEn is high, and holds its value while rdEn is low.
- R7: Address bits above the range an organization needs are ignored.
- R8: Codes 110 and 111 are invalid. A write under an invalid code changes nothing, and a read under an invalid code loads zero.
- R9: A read and a write on the same clock edge that touch different bits both behave correctly, even when they share a 9-bit group.
- R10: When a read and a write touch the same bits on the same edge, the written data is stored correctly and the read result is unspecified (driven to X).
- R11: Driving rstN low clears rdData at once, without waiting for a clock. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write port clock |
| wrEn | input | 1 | Write enable, active high |
| wrCfg | input | 3 | Write port organization code |
| wrAddr | input | 12 | Write word address |
| wrData | input | 36 | Write data, low bits used in narrow organizations |
| rdClk | input | 1 | Read port clock |
| rstN | input | 1 | Active-low reset of the read output register |
| rdEn | input | 1 | Read enable, loads the output register |
| rdCfg | input | 3 | Read port organization code |
| rdAddr | input | 12 | Read word address |
| rdData | output | 36 | Registered read data |

## Verification
Every organization is written and read back at its own width, using values that fill the whole word. This shows that each code maps to the right groups. A 36-bit row is then read back at the 18-, 9- and 4-bit widths, and a byte built one bit at a time is read back at the 4- and 2-bit widths. These cross-width reads would expose swapped lanes, a wrong shift, or a narrow mode that touches bit 8 of a group. Write data with the upper bits set, addresses with the unused bits set, and invalid codes each show that the block ignores what it must ignore. A shared-group write and read on the same edge separates a true bit overlap from a mere match of group index.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 36;
  localparam int GRP_W    = 9;
  localparam int NARROW_W = 8;
  localparam int LANES    = DATA_W / GRP_W;
  localparam int GRP_N    = 512;
  localparam int GRP_AW   = $clog2(GRP_N);
  localparam int SHIFT_W  = $clog2(NARROW_W);

  typedef enum logic [2:0] {
    ORG_X1  = 3'b000,
    ORG_X2  = 3'b001,
    ORG_X4  = 3'b010,
    ORG_X9  = 3'b011,
    ORG_X18 = 3'b100,
    ORG_X36 = 3'b101
  } org_e;

  // strobes from a port decoder to the array
  typedef struct packed {
    logic               ok;
    logic               narrow;
    logic [LANES-1:0]   laneOn;
    logic [GRP_AW-1:0]  grpBase;
    logic [GRP_W-1:0]   bitMask;
    logic [SHIFT_W-1:0] bitShift;
  } port_stb_t;
endpackage

// File: rtl/mrr_port_decode.sv
module mrr_port_decode
  import mrr_pkg::*;
(
  input  logic [2:0]        cfg,
  input  logic [ADDR_W-1:0] addr,
  output port_stb_t         stb
);
  always_comb begin
    stb = '0;
    stb.bitMask = '1;
    case (cfg)
      ORG_X36: begin
        stb.ok      = 1'b1;
        stb.laneOn  = 4'b1111;
        stb.grpBase = {addr[6:0], 2'b00};
      end
      ORG_X18: begin
        stb.ok      = 1'b1;
        stb.laneOn  = 4'b0011;
        stb.grpBase = {addr[7:0], 1'b0};
      end
      ORG_X9: begin
        stb.ok      = 1'b1;
        stb.laneOn  = 4'b0001;
        stb.grpBase = addr[8:0];
      end
      ORG_X4: begin
        stb.ok       = 1'b1;
        stb.narrow   = 1'b1;
        stb.laneOn   = 4'b0001;
        stb.grpBase  = addr[9:1];
        stb.bitShift = {addr[0], 2'b00};
        stb.bitMask  = 9'h00F << stb.bitShift;
      end
      ORG_X2: begin
        stb.ok       = 1'b1;
        stb.narrow   = 1'b1;
        stb.laneOn   = 4'b0001;
        stb.grpBase  = addr[10:2];
        stb.bitShift = {addr[1:0], 1'b0};
        stb.bitMask  = 9'h003 << stb.bitShift;
      end
      ORG_X1: begin
        stb.ok       = 1'b1;
        stb.narrow   = 1'b1;
        stb.laneOn   = 4'b0001;
        stb.grpBase  = addr[11:3];
        stb.bitShift = addr[2:0];
        stb.bitMask  = 9'h001 << stb.bitShift;
      end
      default: begin
        stb.bitMask = '0;
      end
    endcase
  end
endmodule

// File: rtl/mrr_collide.sv
module mrr_collide
  import mrr_pkg::*;
(
  input  logic      wrEn,
  input  port_stb_t wrStb,
  input  logic      rdEn,
  input  port_stb_t rdStb,
  output logic      hit
);
  always_comb begin
    hit = 1'b0;
    if (wrEn && rdEn && wrStb.ok && rdStb.ok) begin
      for (int w = 0; w < LANES; w++) begin
        for (int r = 0; r < LANES; r++) begin
          if (wrStb.laneOn[w] && rdStb.laneOn[r] &&
              ((wrStb.grpBase | GRP_AW'(w)) == (rdStb.grpBase | GRP_AW'(r))) &&
              (|(wrStb.bitMask & rdStb.bitMask)))
            hit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mrr_array.sv
module mrr_array
  import mrr_pkg::*;
(
  input  logic              wrClk,
  input  logic              wrEn,
  input  port_stb_t         wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              rdEn,
  input  port_stb_t         rdStb,
  input  logic              hit,
  output logic [DATA_W-1:0] rdData
);
  logic [GRP_W-1:0]  mem [GRP_N];
  logic [GRP_W-1:0]  laneData [LANES];
  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneData[g] = wrStb.narrow ? (wrData[GRP_W-1:0] << wrStb.bitShift)
                                      : wrData[g*GRP_W +: GRP_W];
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && wrStb.ok) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrStb.laneOn[i])
          mem[wrStb.grpBase | GRP_AW'(i)] <=
            (mem[wrStb.grpBase | GRP_AW'(i)] & ~wrStb.bitMask) |
            (laneData[i] & wrStb.bitMask);
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (rdStb.ok) begin
      if (rdStb.narrow) begin
        rdWord[GRP_W-1:0] = (mem[rdStb.grpBase] & rdStb.bitMask) >> rdStb.bitShift;
      end else begin
        for (int i = 0; i < LANES; i++) begin
          if (rdStb.laneOn[i])
            rdWord[i*GRP_W +: GRP_W] = mem[rdStb.grpBase | GRP_AW'(i)];
        end
      end
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn)
      rdData <= hit ? 'x : rdWord;
  end
endmodule

// File: rtl/mixed_ratio_ram.sv
module mixed_ratio_ram
  import mrr_pkg::*;
(
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [2:0]        wrCfg,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [2:0]        rdCfg,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  port_stb_t wrStb;
  port_stb_t rdStb;
  logic      collideHit;

  mrr_port_decode i_wrDec (.cfg(wrCfg), .addr(wrAddr), .stb(wrStb));
  mrr_port_decode i_rdDec (.cfg(rdCfg), .addr(rdAddr), .stb(rdStb));

  mrr_collide i_coll (
    .wrEn(wrEn), .wrStb(wrStb), .rdEn(rdEn), .rdStb(rdStb), .hit(collideHit)
  );

  mrr_array i_arr (
    .wrClk(wrClk), .wrEn(wrEn), .wrStb(wrStb), .wrData(wrData),
    .rdClk(rdClk), .rstN(rstN), .rdEn(rdEn), .rdStb(rdStb),
    .hit(collideHit), .rdData(rdData)
  );
endmodule

// File: rtl/mrr_checker.sv
module mrr_checker
  import mrr_pkg::*;
(
  input logic              rdClk,
  input logic              rstN,
  input logic              rdEn,
  input logic [2:0]        rdCfg,
  input logic [DATA_W-1:0] rdData,
  input logic              hit
);
  // R6: output register holds while the enable is low
  p_hold_idle_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R3: narrow reads leave the upper bits at zero
  p_narrow_upper_zero_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && !hit && (rdCfg < 3'b011)) |=> (rdData[DATA_W-1:4] == '0));

  // R3: 9- and 18-bit reads leave the upper bits at zero
  p_mid_upper_zero_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && !hit && (rdCfg == 3'b011 || rdCfg == 3'b100))
      |=> (rdData[DATA_W-1:18] == '0));

  // R8: an invalid read code loads zero
  p_bad_code_zero_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && (rdCfg > 3'b101)) |=> (rdData == '0));

  // R11: reset leaves the output register cleared
  p_reset_clears_r11: assert property (@(posedge rdClk)
    !rstN |=> (rdData == '0));
endmodule

bind mixed_ratio_ram mrr_checker i_chk (
  .rdClk(rdClk), .rstN(rstN), .rdEn(rdEn), .rdCfg(rdCfg),
  .rdData(rdData), .hit(collideHit)
);

// File: tb/test_mixed_ratio_ram.sv
module test_mixed_ratio_ram;
  localparam logic [2:0] C36 = 3'b101, C18 = 3'b100, C9 = 3'b011,
                         C4 = 3'b010, C2 = 3'b001, C1 = 3'b000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] wrCfg = '0, rdCfg = '0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [35:0] wrData = '0;
  logic [35:0] rdData;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mixed_ratio_ram i_mixed_ratio_ram (
    .wrClk(clk), .wrEn(wrEn), .wrCfg(wrCfg), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(clk), .rstN(rstN), .rdEn(rdEn), .rdCfg(rdCfg), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] c, input logic [11:0] a, input logic [35:0] d);
    @(negedge clk);
    wrCfg = c; wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] c, input logic [11:0] a, output logic [35:0] q);
    @(negedge clk);
    rdCfg = c; rdAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    check("R11 reset value", rdData, 36'h0);
    rstN = 1'b1;
  endtask

  task automatic tSameWidth();
    logic [35:0] q;
    doWrite(C36, 12'd1, 36'h1_2345_6789);
    doWrite(C18, 12'd10, 36'h2ABCD);
    doWrite(C9, 12'd30, 36'h1C3);
    doWrite(C4, 12'd128, 36'h9);
    doWrite(C2, 12'd280, 36'h2);
    doWrite(C1, 12'd640, 36'h1);
    doRead(C36, 12'd1, q);   check("R1 R2 x36 round trip", q, 36'h1_2345_6789);
    doRead(C18, 12'd10, q);  check("R1 R2 x18 round trip", q, 36'h2ABCD);
    doRead(C9, 12'd30, q);   check("R1 R2 x9 round trip", q, 36'h1C3);
    doRead(C4, 12'd128, q);  check("R1 R2 R3 x4 round trip", q, 36'h9);
    doRead(C2, 12'd280, q);  check("R1 R2 R3 x2 round trip", q, 36'h2);
    doRead(C1, 12'd640, q);  check("R1 R2 R3 x1 round trip", q, 36'h1);
  endtask

  task automatic tWidthConvert();
    logic [35:0] q;
    logic [35:0] v = 36'hA_BCDE_F012;
    doWrite(C36, 12'd10, v);
    for (int i = 0; i < 4; i++) begin
      doRead(C9, 12'(40 + i), q);
      check("R4 x36 to x9 lane", q, {27'h0, v[9*i +: 9]});
    end
    doRead(C18, 12'd20, q); check("R4 x36 to x18 low", q, {18'h0, v[17:0]});
    doRead(C18, 12'd21, q); check("R4 x36 to x18 high", q, {18'h0, v[35:18]});
    doRead(C4, 12'd80, q);  check("R5 x36 to x4 low", q, {32'h0, v[3:0]});
    doRead(C4, 12'd81, q);  check("R5 x36 to x4 high", q, {32'h0, v[7:4]});
  endtask

  task automatic tNarrowPack();
    logic [35:0] q;
    logic [7:0] pat = 8'hB2;
    for (int k = 0; k < 8; k++) doWrite(C1, 12'(2400 + k), {35'h0, pat[k]});
    doRead(C4, 12'd600, q);  check("R5 x1 to x4 low", q, 36'h2);
    doRead(C4, 12'd601, q);  check("R5 x1 to x4 high", q, 36'hB);
    doRead(C2, 12'd1203, q); check("R5 x1 to x2 top", q, 36'h2);
    doWrite(C9, 12'd301, 36'h100);
    doWrite(C4, 12'd602, 36'h0);
    doWrite(C4, 12'd603, 36'h5);
    doRead(C9, 12'd301, q);  check("R5 bit 8 kept by narrow writes", q, 36'h150);
    doWrite(C9, 12'd302, 36'h0);
    doWrite(C2, 12'd1208, 36'hF_FFFF_FFFD);
    doRead(C9, 12'd302, q);  check("R3 upper write data ignored", q, 36'h001);
  endtask

  task automatic tReadHold();
    logic [35:0] q;
    doRead(C36, 12'd1, q);
    @(negedge clk);
    rdCfg = C9; rdAddr = 12'd30; rdEn = 1'b0;
    @(negedge clk);
    check("R6 hold while enable low", rdData, 36'h1_2345_6789);
    rdEn = 1'b1;
    #1 check("R6 no change before edge", rdData, 36'h1_2345_6789);
    @(negedge clk);
    rdEn = 1'b0;
    check("R6 one-cycle latency", rdData, 36'h1C3);
  endtask

  task automatic tAddrHigh();
    logic [35:0] q;
    doWrite(C36, 12'hF83, 36'h7_0F0F_1234);
    doRead(C36, 12'h003, q); check("R7 x36 upper address ignored", q, 36'h7_0F0F_1234);
    doWrite(C9, 12'hE1F, 36'h0AA);
    doRead(C9, 12'h01F, q);  check("R7 x9 upper address ignored", q, 36'h0AA);
  endtask

  task automatic tBadCode();
    logic [35:0] q;
    doWrite(C36, 12'd5, 36'h5_5555_AAAA);
    doWrite(3'b111, 12'd5, 36'h0);
    doWrite(3'b110, 12'd5, 36'h0);
    doRead(C36, 12'd5, q);   check("R8 invalid write ignored", q, 36'h5_5555_AAAA);
    doRead(3'b111, 12'd5, q); check("R8 invalid read 111 zero", q, 36'h0);
    doRead(C36, 12'd5, q);
    doRead(3'b110, 12'd5, q); check("R8 invalid read 110 zero", q, 36'h0);
  endtask

  task automatic tSameCycle();
    logic [35:0] q;
    doWrite(C9, 12'd400, 36'h0A5);
    @(negedge clk);
    wrCfg = C4; wrAddr = 12'd801; wrData = 36'hC; wrEn = 1'b1;
    rdCfg = C4; rdAddr = 12'd800; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 same-group read during write", rdData, 36'h5);
    doRead(C9, 12'd400, q);  check("R9 same-group write stored", q, 36'h0C5);
  endtask

  task automatic tCollision();
    logic [35:0] q;
    doWrite(C36, 12'd50, 36'h0);
    @(negedge clk);
    wrCfg = C36; wrAddr = 12'd50; wrData = 36'hD_EAD0_BEEF; wrEn = 1'b1;
    rdCfg = C36; rdAddr = 12'd50; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    doRead(C36, 12'd50, q);  check("R10 colliding write stored", q, 36'hD_EAD0_BEEF);
  endtask

  task automatic tResetKeeps();
    logic [35:0] q;
    doRead(C36, 12'd1, q);
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R11 async clear", rdData, 36'h0);
    @(negedge clk);
    rstN = 1'b1;
    doRead(C36, 12'd1, q);   check("R11 array kept over reset", q, 36'h1_2345_6789);
  endtask

  initial begin
    tReset();
    tSameWidth();
    tWidthConvert();
    tNarrowPack();
    tReadHold();
    tAddrHigh();
    tBadCode();
    tSameCycle();
    tCollision();
    tResetKeeps();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule